// File: doc/BRIEF.md
# DRAM Strobe Cycle-Type Classifier

This block sits on the device side of an asynchronous DRAM strobe interface. It watches the row strobe, column strobe, write strobe and output-enable strobe, all active low and already synchronized to a fast sampling clock. From the order of their edges and from the tick counts between those edges it names every memory cycle. The possible names are a row-only refresh, a column-before-row refresh, a read, an early write, a read-modify-write, a further access within the same open row, and the start of self refresh. It also decides, tick by tick, whether the data pins may be driven, and it raises a pulse when a strobe low time or precharge time is too short.

The block can serve as a protocol checker beside a memory controller, or as the front end of a behavioural memory model that needs to know what each access means. Every time span is counted in sampling-clock ticks against parameter thresholds. A column-address event input marks when a new column address is presented, so that the address-to-write delay can be judged.

Results leave as a one-cycle pulse (`cyc_valid`) with the class beside it. There is no back-pressure: the consumer must take each pulse in the cycle it appears, because strobe traffic cannot be stalled. An input edge seen at clock edge k shows its effect on the registered outputs right after edge k.

Top module: `dram_cycle_classifier`

## Requirements
- R1: If the column strobe is already low (and not falling in the same tick) when the row strobe falls, the cycle is a refresh of column-before-row type. When the row strobe rises after at most CBR_MAX ticks low, `cyc_type` bit 1 is reported.
- R2: A row-strobe low period with no column-strobe fall reports `cyc_type` bit 0 when the row strobe rises.
- R3: For the first column access of a row cycle with the write strobe high at the column fall, bit 2 (read) is reported when that access closes. `dq_oe` goes high in the tick of the column fall if output enable is low.
- R4: For a column access with the write strobe already low at the column fall, bit 3 (early write) is reported, and `dq_oe` stays low for that access.
- R5: The write strobe may fall later within an open read access. If at least RAS_WE_MIN ticks have passed since the row fall, CAS_WE_MIN since the column fall and COL_WE_MIN since the last column-address event, bit 4 (read-modify-write) is reported and `dq_oe` keeps driving.
- R6: A late write-strobe fall that misses any of those three minimums makes the access indeterminate. It is reported with `cyc_ambig` high and `cyc_type` all zero, and the drive decision is withdrawn.
- R7: A second or later column access within one row-low period reports bit 5 (page continuation).
- R8: Once on, `dq_oe` stays on through a column rise while the row strobe is still low. It turns off OFF_DLY ticks after the tick in which both row and column strobes are high, output enable goes high, or the write strobe rises.
- R9: With both strobes low in a column-before-row cycle for SELF_MIN ticks, bit 6 (self refresh) is reported once, while still low, and nothing is reported at the later row rise. A low time above CBR_MAX that stays under SELF_MIN is reported as indeterminate.
- R10: `timing_viol` pulses when the row strobe rises after fewer than RAS_LOW_MIN ticks low. It also pulses when a page-mode column fall comes fewer than CAS_PRE_MIN ticks after the previous column rise.
- R11: In reset, and after it until a cycle completes, `cyc_valid`, `cyc_type`, `cyc_ambig`, `dq_oe` and `timing_viol` are all low.
- R12: If the row strobe falls while a column access is still open (hidden refresh), that access is reported in the same tick and the new row period is treated as column-before-row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low, synchronized |
| cas_n | input | 1 | Column strobe, active low, synchronized |
| we_n | input | 1 | Write strobe, active low, synchronized |
| oe_n | input | 1 | Output enable, active low, synchronized |
| col_evt | input | 1 | One-tick pulse when a new column address is presented |
| cyc_valid | output | 1 | Classification pulse |
| cyc_type | output | 7 | One-hot class: 0 row-only, 1 CBR, 2 read, 3 early write, 4 RMW, 5 page, 6 self refresh |
| cyc_ambig | output | 1 | Indeterminate class, valid with `cyc_valid` |
| dq_oe | output | 1 | Data output may drive |
| timing_viol | output | 1 | Short low or precharge time pulse |

## Verification
The bench aims at the tick boundaries where a wrong comparator or a wrong edge order changes the class. It drives a write-strobe fall just inside the three delay windows and another one well short of them. A design that mixes up the thresholds would report a read-modify-write where the access is indeterminate, or the reverse, and would leave `dq_oe` on or off in the wrong case. It checks that data drive survives a column rise while the row is low and ends exactly OFF_DLY ticks after the turn-off event. An early or late cut would show at those sample points. Hidden refresh, a one-tick page precharge, a too-short row pulse and a self-refresh hold are also driven, since a design that resets its access state at the wrong edge loses or duplicates reports there.

// File: rtl/dram_cls_pkg.sv
package dram_cls_pkg;
  // Strobe indices inside the tracked vector
  localparam int NSTRB    = 3;
  localparam int STRB_RAS = 0;
  localparam int STRB_CAS = 1;
  localparam int STRB_WE  = 2;

  // Interval timers
  localparam int NTMR     = 4;
  localparam int TMR_RAS  = 0;  // since row fall
  localparam int TMR_CAS  = 1;  // since column fall
  localparam int TMR_COL  = 2;  // since column address event or row fall
  localparam int TMR_CASP = 3;  // since column rise (precharge)

  // Classes, one bit each in the reported type
  localparam int NCLS        = 7;
  localparam int CLS_RASONLY = 0;
  localparam int CLS_CBR     = 1;
  localparam int CLS_READ    = 2;
  localparam int CLS_EWR     = 3;
  localparam int CLS_RMW     = 4;
  localparam int CLS_PAGE    = 5;
  localparam int CLS_SELF    = 6;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_NORM = 2'd1,
    MODE_CBR  = 2'd2
  } cyc_mode_e;

  typedef enum logic [1:0] {
    ACC_READ = 2'd0,
    ACC_EWR  = 2'd1,
    ACC_RMW  = 2'd2,
    ACC_AMB  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic fall;
    logic rise;
  } edge_t;
endpackage

// File: rtl/dram_strobe_track.sv
module dram_strobe_track
  import dram_cls_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSTRB-1:0]          strb_n,
  input  logic                      col_evt,
  output edge_t [NSTRB-1:0]         edg,
  output logic [NTMR-1:0][CW-1:0]   tmr
);
  localparam logic [CW-1:0] TMAX = '1;
  localparam logic [CW-1:0] TONE = CW'(1);

  logic [NSTRB-1:0] prev_q;
  logic [NTMR-1:0]  start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= strb_n;
  end

  for (genvar g = 0; g < NSTRB; g++) begin : g_edge
    assign edg[g].fall = prev_q[g] & ~strb_n[g];
    assign edg[g].rise = ~prev_q[g] & strb_n[g];
  end

  assign start[TMR_RAS]  = edg[STRB_RAS].fall;
  assign start[TMR_CAS]  = edg[STRB_CAS].fall;
  assign start[TMR_COL]  = edg[STRB_RAS].fall | col_evt;
  assign start[TMR_CASP] = edg[STRB_CAS].rise;

  // Saturating tick counters; reset value means "long ago"
  for (genvar t = 0; t < NTMR; t++) begin : g_tmr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              tmr[t] <= TMAX;
      else if (start[t])       tmr[t] <= TONE;
      else if (tmr[t] != TMAX) tmr[t] <= tmr[t] + TONE;
    end
  end
endmodule

// File: rtl/dram_cycle_fsm.sv
module dram_cycle_fsm
  import dram_cls_pkg::*;
#(
  parameter int CW          = 16,
  parameter int RAS_WE_MIN  = 7,
  parameter int CAS_WE_MIN  = 3,
  parameter int COL_WE_MIN  = 4,
  parameter int RAS_LOW_MIN = 5,
  parameter int CAS_PRE_MIN = 2,
  parameter int CBR_MAX     = 1000,
  parameter int SELF_MIN    = 10000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ras_n,
  input  logic                    cas_n,
  input  logic                    we_n,
  input  edge_t [NSTRB-1:0]       edg,
  input  logic [NTMR-1:0][CW-1:0] tmr,
  output logic                    arm_nxt,
  output logic                    cyc_valid,
  output logic [NCLS-1:0]         cyc_type,
  output logic                    cyc_ambig,
  output logic                    timing_viol
);
  localparam logic [CW-1:0] RWD_T  = CW'(RAS_WE_MIN);
  localparam logic [CW-1:0] CWD_T  = CW'(CAS_WE_MIN);
  localparam logic [CW-1:0] AWD_T  = CW'(COL_WE_MIN);
  localparam logic [CW-1:0] RLOW_T = CW'(RAS_LOW_MIN);
  localparam logic [CW-1:0] CPRE_T = CW'(CAS_PRE_MIN);
  localparam logic [CW-1:0] CBR_T  = CW'(CBR_MAX);
  localparam logic [CW-1:0] SELF_T = CW'(SELF_MIN);

  cyc_mode_e mode_q, mode_d;
  acc_kind_e kind_q, kind_d;
  logic cas_seen_q, cas_seen_d;
  logic open_q, open_d;
  logic first_q, first_d;
  logic self_q, self_d;
  logic arm_q;
  logic emit, amb, viol;
  logic [NCLS-1:0] typ;

  always_comb begin
    mode_d     = mode_q;
    kind_d     = kind_q;
    cas_seen_d = cas_seen_q;
    open_d     = open_q;
    first_d    = first_q;
    self_d     = self_q;
    arm_nxt    = arm_q;
    emit       = 1'b0;
    amb        = 1'b0;
    viol       = 1'b0;
    typ        = '0;

    // Close an open column access: column rise, or hidden refresh row fall
    if (open_q && (edg[STRB_CAS].rise || (edg[STRB_RAS].fall && !cas_n))) begin
      emit   = 1'b1;
      open_d = 1'b0;
      if (kind_q == ACC_AMB) amb = 1'b1;
      else if (!first_q)     typ[CLS_PAGE] = 1'b1;
      else begin
        case (kind_q)
          ACC_EWR: typ[CLS_EWR]  = 1'b1;
          ACC_RMW: typ[CLS_RMW]  = 1'b1;
          default: typ[CLS_READ] = 1'b1;
        endcase
      end
    end

    // Row fall: choose refresh-by-column-first or normal row cycle
    if (edg[STRB_RAS].fall) begin
      cas_seen_d = 1'b0;
      self_d     = 1'b0;
      mode_d     = (!cas_n && !edg[STRB_CAS].fall) ? MODE_CBR : MODE_NORM;
    end

    // Write strobe rising ends any drive
    if (edg[STRB_WE].rise) arm_nxt = 1'b0;

    // Column fall inside a normal row cycle opens an access
    if (edg[STRB_CAS].fall && !ras_n && mode_d == MODE_NORM) begin
      if (cas_seen_d && tmr[TMR_CASP] < CPRE_T) viol = 1'b1;
      first_d    = !cas_seen_d;
      cas_seen_d = 1'b1;
      open_d     = 1'b1;
      kind_d     = we_n ? ACC_READ : ACC_EWR;
      arm_nxt    = we_n;
    end

    // Late write strobe fall inside an open read access
    if (edg[STRB_WE].fall && open_q && kind_q == ACC_READ && !cas_n &&
        !edg[STRB_CAS].fall && !edg[STRB_RAS].fall) begin
      if (tmr[TMR_RAS] >= RWD_T && tmr[TMR_CAS] >= CWD_T && tmr[TMR_COL] >= AWD_T)
        kind_d = ACC_RMW;
      else begin
        kind_d  = ACC_AMB;
        arm_nxt = 1'b0;
      end
    end

    // Both strobes high: cycle over, output released
    if (ras_n && cas_n) begin
      arm_nxt = 1'b0;
      mode_d  = MODE_IDLE;
    end

    // Row rise: low-time check and refresh reports
    if (edg[STRB_RAS].rise) begin
      if (tmr[TMR_RAS] < RLOW_T) viol = 1'b1;
      if (mode_q == MODE_NORM && !cas_seen_q) begin
        emit = 1'b1;
        typ[CLS_RASONLY] = 1'b1;
      end else if (mode_q == MODE_CBR && !self_q) begin
        emit = 1'b1;
        if (tmr[TMR_RAS] <= CBR_T) typ[CLS_CBR] = 1'b1;
        else                       amb = 1'b1;
      end
    end

    // Self refresh entry while both strobes stay low
    if (mode_q == MODE_CBR && !ras_n && !cas_n && !self_q && tmr[TMR_RAS] >= SELF_T) begin
      emit   = 1'b1;
      self_d = 1'b1;
      typ[CLS_SELF] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_IDLE;
      kind_q      <= ACC_READ;
      cas_seen_q  <= 1'b0;
      open_q      <= 1'b0;
      first_q     <= 1'b0;
      self_q      <= 1'b0;
      arm_q       <= 1'b0;
      cyc_valid   <= 1'b0;
      cyc_type    <= '0;
      cyc_ambig   <= 1'b0;
      timing_viol <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      kind_q      <= kind_d;
      cas_seen_q  <= cas_seen_d;
      open_q      <= open_d;
      first_q     <= first_d;
      self_q      <= self_d;
      arm_q       <= arm_nxt;
      cyc_valid   <= emit;
      cyc_type    <= typ;
      cyc_ambig   <= amb;
      timing_viol <= viol;
    end
  end

  // R1: a definite report names exactly one class
  p_type_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_ambig) |-> ($countones(cyc_type) == 1));

  // R2: a row-only report follows a row rise seen by the tracker
  p_rasonly_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type[CLS_RASONLY]) |-> $past(edg[STRB_RAS].rise));

  // R6: an indeterminate report carries no class bit
  p_ambig_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_ambig |-> (cyc_valid && cyc_type == '0));

  // R9: self refresh entry is reported once per low period
  p_self_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type[CLS_SELF]) |=> !(cyc_valid && cyc_type[CLS_SELF]));

  // R10: violations only follow a row rise or a column fall
  p_viol_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timing_viol |-> $past(edg[STRB_RAS].rise || edg[STRB_CAS].fall));
endmodule

// File: rtl/dram_dq_oe_ctl.sv
module dram_dq_oe_ctl #(
  parameter int OFF_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic oe_n,
  output logic dq_oe
);
  localparam int OW = (OFF_DLY < 2) ? 1 : $clog2(OFF_DLY);
  localparam logic [OW-1:0] LAST = OW'(OFF_DLY - 1);

  logic          req;
  logic [OW-1:0] cnt_q;

  assign req = arm_i & ~oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe <= 1'b0;
      cnt_q <= '0;
    end else if (req) begin
      dq_oe <= 1'b1;
      cnt_q <= '0;
    end else if (dq_oe) begin
      if (cnt_q == LAST) begin
        dq_oe <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + OW'(1);
      end
    end
  end

  // R3: drive only starts after an armed request with output enable low
  p_on_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(arm_i && !oe_n));

  // R8: the turn-off counter never passes the delay
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R8: while idle, the counter rests at zero
  p_idle_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (cnt_q == '0));
endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
  import dram_cls_pkg::*;
#(
  parameter int RAS_WE_MIN  = 7,
  parameter int CAS_WE_MIN  = 3,
  parameter int COL_WE_MIN  = 4,
  parameter int RAS_LOW_MIN = 5,
  parameter int CAS_PRE_MIN = 2,
  parameter int CBR_MAX     = 1000,
  parameter int SELF_MIN    = 10000,
  parameter int OFF_DLY     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            oe_n,
  input  logic            col_evt,
  output logic            cyc_valid,
  output logic [NCLS-1:0] cyc_type,
  output logic            cyc_ambig,
  output logic            dq_oe,
  output logic            timing_viol
);
  localparam int CW = $clog2(SELF_MIN + 2) + 1;

  edge_t [NSTRB-1:0]       edg;
  logic [NTMR-1:0][CW-1:0] tmr;
  logic [NSTRB-1:0]        strb_n;
  logic                    arm_nxt;

  assign strb_n[STRB_RAS] = ras_n;
  assign strb_n[STRB_CAS] = cas_n;
  assign strb_n[STRB_WE]  = we_n;

  dram_strobe_track #(.CW(CW)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb_n  (strb_n),
    .col_evt (col_evt),
    .edg     (edg),
    .tmr     (tmr)
  );

  dram_cycle_fsm #(
    .CW          (CW),
    .RAS_WE_MIN  (RAS_WE_MIN),
    .CAS_WE_MIN  (CAS_WE_MIN),
    .COL_WE_MIN  (COL_WE_MIN),
    .RAS_LOW_MIN (RAS_LOW_MIN),
    .CAS_PRE_MIN (CAS_PRE_MIN),
    .CBR_MAX     (CBR_MAX),
    .SELF_MIN    (SELF_MIN)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .edg         (edg),
    .tmr         (tmr),
    .arm_nxt     (arm_nxt),
    .cyc_valid   (cyc_valid),
    .cyc_type    (cyc_type),
    .cyc_ambig   (cyc_ambig),
    .timing_viol (timing_viol)
  );

  dram_dq_oe_ctl #(.OFF_DLY(OFF_DLY)) u_dq (
    .clk   (clk),
    .rst_n (rst_n),
    .arm_i (arm_nxt),
    .oe_n  (oe_n),
    .dq_oe (dq_oe)
  );

  // R4: an early write access is never reported while data is being driven
  p_ewr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type[CLS_EWR]) |-> !dq_oe);
endmodule

// File: tb/dram_cycle_classifier_tb_top.sv
module dram_cycle_classifier_tb_top;
  localparam logic [6:0] T_NONE = 7'b0000000;
  localparam logic [6:0] T_RO   = 7'b0000001;
  localparam logic [6:0] T_CBR  = 7'b0000010;
  localparam logic [6:0] T_RD   = 7'b0000100;
  localparam logic [6:0] T_EW   = 7'b0001000;
  localparam logic [6:0] T_RMW  = 7'b0010000;
  localparam logic [6:0] T_PG   = 7'b0100000;
  localparam logic [6:0] T_SELF = 7'b1000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, col_evt = 1'b0;
  logic cyc_valid, cyc_ambig, dq_oe, timing_viol;
  logic [6:0] cyc_type;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [6:0] typ;
    logic       amb;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  dram_cycle_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .col_evt(col_evt), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
    .cyc_ambig(cyc_ambig), .dq_oe(dq_oe), .timing_viol(timing_viol)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [6:0] t, input logic a, input string tag);
    exp_t e;
    e.typ = t; e.amb = a; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic check(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a class is reported
  always @(negedge clk) begin
    if (rst_n && !done && cyc_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected report: type=%b ambig=%b expected none", cyc_type, cyc_ambig);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (cyc_type !== e.typ || cyc_ambig !== e.amb) begin
          n_fail++;
          $display("FAIL %s: type=%b ambig=%b expected type=%b ambig=%b",
                   e.tag, cyc_type, cyc_ambig, e.typ, e.amb);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    // R11: quiet outputs in reset
    check("R11 valid", cyc_valid, 1'b0);
    check("R11 dq_oe", dq_oe, 1'b0);
    check("R11 viol", timing_viol, 1'b0);
    rst_n = 1'b1;
    tick(2);
    check("R11 type", |cyc_type, 1'b0);

    // R2: row-only refresh, long enough
    push(T_RO, 1'b0, "R2 row-only");
    ras_n = 1'b0; tick(6);
    ras_n = 1'b1; tick;
    check("R10 no viol long row", timing_viol, 1'b0);
    tick(3);

    // R1: column before row refresh
    push(T_CBR, 1'b0, "R1 cbr");
    cas_n = 1'b0; tick;
    ras_n = 1'b0; tick(6);
    ras_n = 1'b1; tick;
    cas_n = 1'b1; tick(3);

    // R3/R8: read with EDO hold and delayed turn-off
    push(T_RD, 1'b0, "R3 read");
    oe_n = 1'b0;
    ras_n = 1'b0; tick(2);
    cas_n = 1'b0; tick;
    check("R3 drive on", dq_oe, 1'b1);
    tick(3);
    cas_n = 1'b1; tick;
    check("R8 hold after column rise", dq_oe, 1'b1);
    ras_n = 1'b1; tick;
    check("R8 still on during delay", dq_oe, 1'b1);
    tick;
    check("R8 off after delay", dq_oe, 1'b0);
    oe_n = 1'b1; tick(3);

    // R4: early write
    push(T_EW, 1'b0, "R4 early write");
    oe_n = 1'b0; we_n = 1'b0;
    ras_n = 1'b0; tick(2);
    cas_n = 1'b0; tick;
    check("R4 no drive", dq_oe, 1'b0);
    tick(3);
    cas_n = 1'b1; ras_n = 1'b1; tick;
    check("R4 no drive end", dq_oe, 1'b0);
    we_n = 1'b1; oe_n = 1'b1; tick(3);

    // R5: read-modify-write at the window edge (8/6/7 ticks vs 7/3/4)
    push(T_RMW, 1'b0, "R5 rmw");
    oe_n = 1'b0;
    ras_n = 1'b0; tick;
    col_evt = 1'b1; tick;
    col_evt = 1'b0; cas_n = 1'b0; tick;
    check("R5 read drive", dq_oe, 1'b1);
    tick(5);
    we_n = 1'b0; tick;
    check("R5 drive kept", dq_oe, 1'b1);
    oe_n = 1'b1; tick;
    check("R8 oe off delay", dq_oe, 1'b1);
    tick;
    check("R8 oe off", dq_oe, 1'b0);
    cas_n = 1'b1; ras_n = 1'b1; tick;
    we_n = 1'b1; tick(3);

    // R6: late but too early write strobe
    push(T_NONE, 1'b1, "R6 indeterminate");
    oe_n = 1'b0;
    ras_n = 1'b0; tick(2);
    cas_n = 1'b0; tick;
    we_n = 1'b0; tick;
    tick;
    check("R6 drive withdrawn", dq_oe, 1'b0);
    tick(2);
    cas_n = 1'b1; ras_n = 1'b1; tick;
    we_n = 1'b1; oe_n = 1'b1; tick(3);

    // R7/R10: page accesses, second precharge too short
    push(T_RD, 1'b0, "R7 first access");
    push(T_PG, 1'b0, "R7 page 1");
    push(T_PG, 1'b0, "R7 page 2");
    oe_n = 1'b0;
    ras_n = 1'b0; tick(2);
    cas_n = 1'b0; tick(2);
    cas_n = 1'b1; tick(2);
    cas_n = 1'b0; tick;
    check("R10 precharge ok", timing_viol, 1'b0);
    tick;
    cas_n = 1'b1; tick;
    cas_n = 1'b0; tick;
    check("R10 short precharge", timing_viol, 1'b1);
    tick;
    check("R10 pulse ends", timing_viol, 1'b0);
    cas_n = 1'b1; tick;
    ras_n = 1'b1; tick(3);
    oe_n = 1'b1; tick(2);

    // R10: too short row low time
    push(T_RO, 1'b0, "R2 short row-only");
    ras_n = 1'b0; tick(2);
    ras_n = 1'b1; tick;
    check("R10 short row", timing_viol, 1'b1);
    tick(3);

    // R12: hidden refresh closes the open read
    push(T_RD, 1'b0, "R12 hidden read");
    push(T_CBR, 1'b0, "R12 hidden cbr");
    oe_n = 1'b0;
    ras_n = 1'b0; tick(2);
    cas_n = 1'b0; tick(4);
    ras_n = 1'b1; tick(2);
    check("R8 hold with column low", dq_oe, 1'b1);
    ras_n = 1'b0; tick(6);
    ras_n = 1'b1; tick;
    cas_n = 1'b1; tick(3);
    oe_n = 1'b1; tick(2);

    // R9: low time between limits is indeterminate
    push(T_NONE, 1'b1, "R9 mid-length cbr");
    cas_n = 1'b0; tick;
    ras_n = 1'b0; tick(2000);
    ras_n = 1'b1; tick;
    cas_n = 1'b1; tick(3);

    // R9: self refresh entry, once, nothing at exit
    push(T_SELF, 1'b0, "R9 self refresh");
    cas_n = 1'b0; tick;
    ras_n = 1'b0; tick(10010);
    ras_n = 1'b1; tick;
    cas_n = 1'b1; tick(5);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R9 leftover reports: got %0d missing expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule